// File: doc/BRIEF.md
# Programmable Interrupt Pin Router

This block steers three general-purpose interrupt input pins and one internal timer/security interrupt source onto sixteen legacy IRQ lines and four advanced-controller IRQ lines. One 16-bit routing register holds the steering choices. Each pin has a 4-bit IRQ number. The internal source has a 3-bit line code and an enable bit.

Each pin takes part in routing only while its function-select input picks the interrupt function. A pin whose selector names one of the excluded IRQ numbers drives nothing. The internal source is the timer status flag ORed with the intruder status flag, and the intruder flag counts only when intruder routing picks the IRQ path. The internal source is routed only when it is enabled and the SCI path is not chosen. Every output line is the OR of all sources mapped onto it. Outputs follow their sources combinationally, so each line stays high exactly as long as its source is high. This suits the level-sensitive handling that legacy lines 9 to 11 need.

Top module: `irq_pin_router`

## Requirements
- R1: After synchronous reset the routing register reads 0000h, and with all sources low every IRQ output is 0.
- R2: A write with wr_be[0]=1 loads bits 7:0 and a write with wr_be[1]=1 loads bits 15:8. A byte whose enable is 0 keeps its value. cfg_q returns exactly the stored value from the cycle after the write edge.
- R3: The register fields are: pin k selector at bits 4k+3:4k (k=0..2), internal-source code at bits 14:12, and internal-source enable at bit 15. With pin_func_sel[k]=1, leg_irq[n] follows pin_lvl[k] when pin k's selector holds n.
- R4: Pin selector values 0, 2, 8 and 13 are excluded. A pin so programmed drives no output, and leg_irq lines 0, 2, 8 and 13 are never driven.
- R5: With pin_func_sel[k]=0, pin k has no effect on any output, whatever its level or selector.
- R6: The internal source is tco_sts OR (intr_sts AND intr_to_irq).
- R7: Internal-source codes map as follows: 0 to leg_irq[9], 1 to leg_irq[10], 2 to leg_irq[11], 3 to no line, and 4 to 7 to adv_irq[0] to adv_irq[3]. At most one adv_irq line is ever high.
- R8: The internal source reaches an output only when bit 15 is 1 and sci_route is 0.
- R9: Sources mapped to the same line are ORed together.
- R10: Outputs are combinational in the sources. A routed line is high while its source is high and falls in the same cycle the source clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables for the write |
| wr_data | input | 16 | Write data |
| cfg_q | output | 16 | Routing register readback |
| pin_lvl | input | 3 | Interrupt pin levels |
| pin_func_sel | input | 3 | Per-pin interrupt-function select |
| tco_sts | input | 1 | Timer status flag |
| intr_sts | input | 1 | Intruder status flag |
| intr_to_irq | input | 1 | Intruder routing picks the IRQ path |
| sci_route | input | 1 | Internal source goes to the SCI path instead |
| leg_irq | output | 16 | Legacy IRQ lines |
| adv_irq | output | 4 | Advanced-controller IRQ lines 20 to 23 |

## Verification
On every cycle the assertions check four things: the excluded legacy lines stay low, at most one advanced line is high, byte writes land or hold per enable, and the outputs are quiet when no source is enabled. Only the bench's scenarios can show the exact mapping of each selector value to its line, the decode of every internal-source code, and the OR merging of sources that share a line. The same holds for a line falling in step with its source flag.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int NUM_PINS  = 3;
    localparam int PIN_SEL_W = 4;
    localparam int INT_SEL_W = 3;
    localparam int LEG_N     = 16;
    localparam int ADV_N     = 4;
    localparam int CFG_W     = 16;

    typedef struct packed {
        logic                                  int_en;
        logic [INT_SEL_W-1:0]                  int_sel;
        logic [NUM_PINS-1:0][PIN_SEL_W-1:0]    pin_sel;
    } route_cfg_t;

    typedef struct packed {
        logic [ADV_N-1:0] adv;
        logic [LEG_N-1:0] leg;
    } irq_vec_t;

    function automatic logic pin_sel_excluded(input logic [PIN_SEL_W-1:0] s);
        case (s)
            4'd0, 4'd2, 4'd8, 4'd13: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

    function automatic logic [LEG_N-1:0] pin_decode(input logic [PIN_SEL_W-1:0] s);
        logic [LEG_N-1:0] one;
        one = {{(LEG_N-1){1'b0}}, 1'b1};
        if (pin_sel_excluded(s)) return '0;
        return one << s;
    endfunction

    function automatic irq_vec_t int_decode(input logic [INT_SEL_W-1:0] s);
        irq_vec_t v;
        v = '0;
        case (s)
            3'd0: v.leg[9]  = 1'b1;
            3'd1: v.leg[10] = 1'b1;
            3'd2: v.leg[11] = 1'b1;
            3'd3: ;
            default: v.adv[s[1:0]] = 1'b1;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/route_cfg_reg.sv
module route_cfg_reg
    import irq_route_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [W/8-1:0]   wr_be,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     q
);
    localparam int NB = W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                q[8*b +: 8] <= 8'h00;
            else if (wr_en && wr_be[b])
                q[8*b +: 8] <= wr_data[8*b +: 8];
        end
    end
endmodule

// File: rtl/pin_router.sv
module pin_router
    import irq_route_pkg::*;
#(
    parameter int NPINS = NUM_PINS
) (
    input  logic [NPINS-1:0][PIN_SEL_W-1:0] pin_sel,
    input  logic [NPINS-1:0]                pin_lvl,
    input  logic [NPINS-1:0]                pin_func_sel,
    output logic [LEG_N-1:0]                leg
);
    logic [LEG_N-1:0] per_pin [NPINS];

    for (genvar k = 0; k < NPINS; k++) begin : g_pin
        assign per_pin[k] = (pin_func_sel[k] && pin_lvl[k]) ? pin_decode(pin_sel[k]) : '0;
    end

    always_comb begin
        leg = '0;
        for (int k = 0; k < NPINS; k++) leg = leg | per_pin[k];
    end
endmodule

// File: rtl/int_src_router.sv
module int_src_router
    import irq_route_pkg::*;
(
    input  logic                 int_en,
    input  logic [INT_SEL_W-1:0] int_sel,
    input  logic                 tco_sts,
    input  logic                 intr_sts,
    input  logic                 intr_to_irq,
    input  logic                 sci_route,
    output irq_vec_t             vec
);
    logic src;
    logic gate;

    assign src  = tco_sts | (intr_sts & intr_to_irq);
    assign gate = int_en & ~sci_route;
    assign vec  = (src && gate) ? int_decode(int_sel) : '0;
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
    import irq_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_be,
    input  logic [15:0]         wr_data,
    output logic [15:0]         cfg_q,
    input  logic [2:0]          pin_lvl,
    input  logic [2:0]          pin_func_sel,
    input  logic                tco_sts,
    input  logic                intr_sts,
    input  logic                intr_to_irq,
    input  logic                sci_route,
    output logic [15:0]         leg_irq,
    output logic [3:0]          adv_irq
);
    route_cfg_t       cfg;
    logic [LEG_N-1:0] pin_leg;
    irq_vec_t         int_vec;

    route_cfg_reg #(.W(CFG_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .q       (cfg_q)
    );

    assign cfg = route_cfg_t'(cfg_q);

    pin_router #(.NPINS(NUM_PINS)) u_pins (
        .pin_sel      (cfg.pin_sel),
        .pin_lvl      (pin_lvl),
        .pin_func_sel (pin_func_sel),
        .leg          (pin_leg)
    );

    int_src_router u_int (
        .int_en      (cfg.int_en),
        .int_sel     (cfg.int_sel),
        .tco_sts     (tco_sts),
        .intr_sts    (intr_sts),
        .intr_to_irq (intr_to_irq),
        .sci_route   (sci_route),
        .vec         (int_vec)
    );

    assign leg_irq = pin_leg | int_vec.leg;
    assign adv_irq = int_vec.adv;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic [15:0] cfg_q,
    input logic [2:0]  pin_func_sel,
    input logic        sci_route,
    input logic [15:0] leg_irq,
    input logic [3:0]  adv_irq
);
    // R4
    excluded_lines_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(leg_irq[0] | leg_irq[2] | leg_irq[8] | leg_irq[13]));

    // R7
    adv_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(adv_irq));

    // R2
    low_byte_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_be[0]) |=> cfg_q[7:0] == $past(wr_data[7:0]));

    // R2
    low_byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_be[0]) |=> $stable(cfg_q[7:0]));

    // R2
    high_byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_be[1]) |=> $stable(cfg_q[15:8]));

    // R5 R8
    quiet_when_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_func_sel == 3'b000 && (!cfg_q[15] || sci_route)) |-> (leg_irq == 16'h0 && adv_irq == 4'h0));
endmodule

bind irq_pin_router irq_router_chk u_chk (.*);

// File: tb/test_irq_pin_router.sv
module test_irq_pin_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] cfg_q;
    logic [2:0]  pin_lvl = 3'b0;
    logic [2:0]  pin_func_sel = 3'b0;
    logic        tco_sts = 1'b0;
    logic        intr_sts = 1'b0;
    logic        intr_to_irq = 1'b0;
    logic        sci_route = 1'b0;
    logic [15:0] leg_irq;
    logic [3:0]  adv_irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    irq_pin_router i_irq_pin_router (.*);

    function automatic logic [19:0] model(input logic [15:0] c);
        logic [15:0] l;
        logic [3:0]  a;
        logic        src;
        l = '0;
        a = '0;
        for (int k = 0; k < 3; k++) begin
            logic [3:0] s;
            s = c[4*k +: 4];
            if (pin_func_sel[k] && pin_lvl[k] && !(s == 0 || s == 2 || s == 8 || s == 13))
                l[s] = 1'b1;
        end
        src = tco_sts | (intr_sts & intr_to_irq);
        if (src && c[15] && !sci_route) begin
            case (c[14:12])
                3'd0: l[9] = 1'b1;
                3'd1: l[10] = 1'b1;
                3'd2: l[11] = 1'b1;
                3'd3: ;
                default: a[c[13:12]] = 1'b1;
            endcase
        end
        return {a, l};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [15:0] c);
        #1;
        chk(req, {12'h0, adv_irq, leg_irq}, {12'h0, model(c)});
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 cfg", {16'h0, cfg_q}, 32'h0);
        chk("R1 outputs", {12'h0, adv_irq, leg_irq}, 32'h0);
    endtask

    task automatic t_byte_writes;
        wr(2'b01, 16'hA5C3);
        chk("R2 low byte", {16'h0, cfg_q}, 32'h00C3);
        wr(2'b10, 16'h7E11);
        chk("R2 high byte", {16'h0, cfg_q}, 32'h7EC3);
        wr(2'b00, 16'hFFFF);
        chk("R2 no enable", {16'h0, cfg_q}, 32'h7EC3);
        wr(2'b11, 16'h1234);
        chk("R2 both", {16'h0, cfg_q}, 32'h1234);
    endtask

    task automatic t_pin_sweep;
        for (int k = 0; k < 3; k++) begin
            for (int s = 0; s < 16; s++) begin
                logic [15:0] c;
                c = 16'h0;
                c[4*k +: 4] = 4'(s);
                wr(2'b11, c);
                pin_func_sel = 3'b111;
                pin_lvl = 3'b000;
                pin_lvl[k] = 1'b1;
                if (s == 0 || s == 2 || s == 8 || s == 13) chk_out("R4 excluded", c);
                else chk_out("R3 pin route", c);
                pin_lvl = 3'b000;
                chk_out("R10 pin low", c);
            end
        end
        pin_func_sel = 3'b000;
    endtask

    task automatic t_pin_gating;
        logic [15:0] c;
        c = 16'h0C53;
        wr(2'b11, c);
        pin_lvl = 3'b111;
        pin_func_sel = 3'b000;
        chk_out("R5 all gated", c);
        pin_func_sel = 3'b010;
        chk_out("R5 one enabled", c);
        pin_func_sel = 3'b101;
        chk_out("R5 two enabled", c);
        pin_lvl = 3'b0;
        pin_func_sel = 3'b0;
    endtask

    task automatic t_int_encoding;
        for (int s = 0; s < 8; s++) begin
            logic [15:0] c;
            c = {1'b1, 3'(s), 12'h0};
            wr(2'b11, c);
            tco_sts = 1'b1;
            chk_out("R7 int code", c);
            tco_sts = 1'b0;
            chk_out("R10 int low", c);
        end
    endtask

    task automatic t_int_gating;
        logic [15:0] c;
        c = 16'hD000;
        wr(2'b11, c);
        intr_sts = 1'b1; intr_to_irq = 1'b0;
        chk_out("R6 intruder not routed", c);
        intr_to_irq = 1'b1;
        chk_out("R6 intruder routed", c);
        sci_route = 1'b1;
        chk_out("R8 sci path", c);
        sci_route = 1'b0;
        c = 16'h5000;
        wr(2'b11, c);
        chk_out("R8 disabled", c);
        intr_sts = 1'b0; intr_to_irq = 1'b0;
    endtask

    task automatic t_or_merge;
        logic [15:0] c;
        c = 16'h8AAA;
        wr(2'b11, c);
        pin_func_sel = 3'b111;
        pin_lvl = 3'b101;
        chk_out("R9 pins shared", c);
        pin_lvl = 3'b000; tco_sts = 1'b1;
        chk_out("R9 int alone", c);
        pin_lvl = 3'b010;
        chk_out("R9 pin and int", c);
        tco_sts = 1'b0;
        chk_out("R10 int cleared", c);
        pin_lvl = 3'b0; pin_func_sel = 3'b0;
    endtask

    task automatic t_level_follow;
        logic [15:0] c;
        c = 16'h9000;
        wr(2'b11, c);
        tco_sts = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk_out("R10 held", c);
        end
        tco_sts = 1'b0;
        chk_out("R10 falls", c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_byte_writes();
        t_pin_sweep();
        t_pin_gating();
        t_int_encoding();
        t_int_gating();
        t_or_merge();
        t_level_follow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule